// File: doc/BRIEF.md
# Keyed Register Write Guard

This block sits between a bus write port and a peripheral's register file. It watches every write (address, data, strobe) and produces the write enable that the register file actually uses. Writes to the guarded address window reach the register file only while the guard is open. The guard opens when each of two key slots holds its own 32-bit unlock word.

The two key slots live inside this block at fixed addresses and can always be written. Each slot remembers only whether its last write carried the right word. Any other value written to either slot, zero included, closes the guard at the next clock edge. Writes outside the guarded window go straight through. Reads are not routed through this block.

Software opens the guard by writing the first word to slot A and the second word to slot B. It closes the guard again by writing zero to both slots.

Top module: `keyed_write_guard`

## Requirements
- R1: After reset the guard is closed (`guard_open` = 0) and neither slot holds its key.
- R2: The guard is open from the clock edge that captures the write after which slot A (address 0x6C) holds 0x83E70B13 and slot B (address 0x70) holds 0x95A4F1E0. The order of the two writes does not matter.
- R3: With only one slot holding its key, the guard stays closed.
- R4: A strobed write of any value other than its key to either slot closes the guard at that clock edge. The other slot keeps its state.
- R5: A strobed write to the guarded window (0x00 to 0x57) while the guard is closed is dropped: `regf_we` stays 0.
- R6: A strobed write to the guarded window while the guard is open asserts `regf_we` in the same cycle.
- R7: A strobed write to an address outside the guarded window and the slots asserts `regf_we` in the same cycle, whatever the guard state.
- R8: Writes to either slot address never assert `regf_we`.
- R9: Swapped keys (slot A given slot B's word and slot B given slot A's word) leave the guard closed.
- R10: With the strobe low, slot addresses and data have no effect on the guard state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | AW (8) | Byte address of the write |
| wr_data | input | DW (32) | Write data |
| regf_we | output | 1 | Gated write enable for the register file |
| guard_open | output | 1 | Guard state: 1 when guarded writes pass |

## Verification
A slot flag stuck set would open the guard after only one key write. That shows at `guard_open` in the cycle after that write, and as a spurious `regf_we` on the next guarded write. A flag that fails to clear would keep the guard open after a relocking write, and the next guarded write would pass. A wrong window decode shows up on the very write that hits the misdecoded address, because `regf_we` is combinational from the strobe. The bench covers unlocking, relocking with zero and with other words, swapped keys, and idle cycles on slot addresses.

// File: rtl/kwg_pkg.sv
package kwg_pkg;
   localparam int unsigned NUM_SLOTS = 2;

   function automatic logic in_window(input logic [31:0] addr,
                                      input logic [31:0] base,
                                      input logic [31:0] span);
      logic [31:0] off;
      off = addr - base;
      return (addr >= base) && (off < span);
   endfunction
endpackage

// File: rtl/kwg_key_slot.sv
module kwg_key_slot #(
   parameter int unsigned    AW   = 8,
   parameter int unsigned    DW   = 32,
   parameter logic [AW-1:0]  ADDR = '0,
   parameter logic [DW-1:0]  KEY  = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   output logic          hit,
   output logic          holds_key
);
   logic match_q;

   assign hit = (wr_addr == ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         match_q <= 1'b0;
      else if (wr_en && hit)
         match_q <= (wr_data == KEY);
   end

   assign holds_key = match_q;
endmodule

// File: rtl/kwg_window_decode.sv
module kwg_window_decode #(
   parameter int unsigned AW   = 8,
   parameter int unsigned BASE = 0,
   parameter int unsigned SPAN = 'h58
) (
   input  logic [AW-1:0] addr,
   output logic          guarded
);
   logic [31:0] addr_ext;

   assign addr_ext = 32'(addr);
   assign guarded  = kwg_pkg::in_window(addr_ext, 32'(BASE), 32'(SPAN));
endmodule

// File: rtl/keyed_write_guard.sv
module keyed_write_guard #(
   parameter int unsigned   AW          = 8,
   parameter int unsigned   DW          = 32,
   parameter logic [AW-1:0] SLOT_A_ADDR = 8'h6C,
   parameter logic [AW-1:0] SLOT_B_ADDR = 8'h70,
   parameter logic [DW-1:0] SLOT_A_KEY  = 32'h83E7_0B13,
   parameter logic [DW-1:0] SLOT_B_KEY  = 32'h95A4_F1E0,
   parameter int unsigned   WIN_BASE    = 'h00,
   parameter int unsigned   WIN_SPAN    = 'h58
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   output logic          regf_we,
   output logic          guard_open
);
   localparam int unsigned NS = kwg_pkg::NUM_SLOTS;
   localparam logic [NS-1:0][AW-1:0] S_ADDR = {SLOT_B_ADDR, SLOT_A_ADDR};
   localparam logic [NS-1:0][DW-1:0] S_KEY  = {SLOT_B_KEY, SLOT_A_KEY};

   if (DW < 32) begin : g_bad_dw
      $error("keyed_write_guard: DW must be at least 32");
   end
   if (SLOT_A_ADDR == SLOT_B_ADDR) begin : g_bad_addr
      $error("keyed_write_guard: slot addresses must differ");
   end
   if (SLOT_A_KEY == SLOT_B_KEY) begin : g_bad_key
      $error("keyed_write_guard: slot keys must differ");
   end

   logic [NS-1:0] slot_hit;
   logic [NS-1:0] slot_ok;
   logic          any_slot;
   logic          guarded;

   for (genvar i = 0; i < NS; i++) begin : g_slot
      kwg_key_slot #(
         .AW   (AW),
         .DW   (DW),
         .ADDR (S_ADDR[i]),
         .KEY  (S_KEY[i])
      ) u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_en     (wr_en),
         .wr_addr   (wr_addr),
         .wr_data   (wr_data),
         .hit       (slot_hit[i]),
         .holds_key (slot_ok[i])
      );
   end

   kwg_window_decode #(
      .AW   (AW),
      .BASE (WIN_BASE),
      .SPAN (WIN_SPAN)
   ) u_decode (
      .addr    (wr_addr),
      .guarded (guarded)
   );

   assign any_slot   = |slot_hit;
   assign guard_open = &slot_ok;
   assign regf_we    = wr_en && !any_slot && (!guarded || guard_open);
endmodule

// File: rtl/keyed_write_guard_chk.sv
module keyed_write_guard_chk #(
   parameter int unsigned   AW          = 8,
   parameter int unsigned   DW          = 32,
   parameter logic [AW-1:0] SLOT_A_ADDR = 8'h6C,
   parameter logic [AW-1:0] SLOT_B_ADDR = 8'h70,
   parameter logic [DW-1:0] SLOT_A_KEY  = 32'h83E7_0B13,
   parameter logic [DW-1:0] SLOT_B_KEY  = 32'h95A4_F1E0,
   parameter int unsigned   WIN_BASE    = 'h00,
   parameter int unsigned   WIN_SPAN    = 'h58
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_en,
   input logic [AW-1:0] wr_addr,
   input logic [DW-1:0] wr_data,
   input logic          regf_we,
   input logic          guard_open
);
   logic a_hit, b_hit, in_win;

   assign a_hit  = (wr_addr == SLOT_A_ADDR);
   assign b_hit  = (wr_addr == SLOT_B_ADDR);
   assign in_win = kwg_pkg::in_window(32'(wr_addr), 32'(WIN_BASE), 32'(WIN_SPAN));

   // R2: the guard opens only on a clock edge that captured a slot write
   p_open_needs_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(guard_open) |-> $past(wr_en && (a_hit || b_hit)));

   // R4: a wrong word in either slot closes the guard
   p_relock_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ((a_hit && wr_data != SLOT_A_KEY) || (b_hit && wr_data != SLOT_B_KEY)))
      |=> !guard_open);

   // R5: guarded writes are dropped while closed
   p_drop_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && in_win && !guard_open) |-> !regf_we);

   // R7: writes outside window and slots always pass
   p_pass_unguarded_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !in_win && !a_hit && !b_hit) |-> regf_we);

   // R8: slot writes never reach the register file
   p_slot_isolated_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (a_hit || b_hit) |-> !regf_we);

   // R10: without a strobe the guard state holds
   p_idle_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(guard_open));
endmodule

bind keyed_write_guard keyed_write_guard_chk #(
   .AW          (AW),
   .DW          (DW),
   .SLOT_A_ADDR (SLOT_A_ADDR),
   .SLOT_B_ADDR (SLOT_B_ADDR),
   .SLOT_A_KEY  (SLOT_A_KEY),
   .SLOT_B_KEY  (SLOT_B_KEY),
   .WIN_BASE    (WIN_BASE),
   .WIN_SPAN    (WIN_SPAN)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_addr    (wr_addr),
   .wr_data    (wr_data),
   .regf_we    (regf_we),
   .guard_open (guard_open)
);

// File: tb/keyed_write_guard_bench.sv
module keyed_write_guard_bench;
   localparam logic [7:0]  A_ADR = 8'h6C;
   localparam logic [7:0]  B_ADR = 8'h70;
   localparam logic [31:0] A_KEY = 32'h83E7_0B13;
   localparam logic [31:0] B_KEY = 32'h95A4_F1E0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        regf_we;
   logic        guard_open;

   int checks = 0;
   int failures = 0;

   typedef struct { logic we; string tag; } exp_t;
   exp_t exp_q[$];

   always #2 clk = ~clk;

   keyed_write_guard u_keyed_write_guard (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .regf_we(regf_we), .guard_open(guard_open)
   );

   // monitor: compares the gated enable of each strobed write
   always @(negedge clk) begin
      if (rst_n && wr_en && exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         checks++;
         if (regf_we !== e.we) begin
            failures++;
            $display("FAIL %s: regf_we=%0b expected=%0b addr=%h", e.tag, regf_we, e.we, wr_addr);
         end
      end
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic exp_we, input string tag);
      @(posedge clk); #1;
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      exp_q.push_back('{we: exp_we, tag: tag});
   endtask

   task automatic idle(input logic [7:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      wr_en = 1'b0; wr_addr = a; wr_data = d;
   endtask

   task automatic chk_open(input logic exp, input string tag);
      @(negedge clk);
      checks++;
      if (guard_open !== exp) begin
         failures++;
         $display("FAIL %s: guard_open=%0b expected=%0b", tag, guard_open, exp);
      end
   endtask

   initial begin
      fork
         begin
            repeat (3) @(posedge clk);
            #1 rst_n = 1'b1;
            chk_open(1'b0, "R1 reset closed");
            wr(8'h40, 32'h1, 1'b0, "R5 guarded write closed");
            wr(8'h80, 32'h2, 1'b1, "R7 unguarded write");
            wr(A_ADR, A_KEY, 1'b0, "R8 slot A write");
            idle(8'h0, 32'h0);
            chk_open(1'b0, "R3 one key only");
            wr(8'h10, 32'h3, 1'b0, "R3 guarded dropped one key");
            wr(B_ADR, B_KEY, 1'b0, "R8 slot B write");
            wr(8'h10, 32'h4, 1'b1, "R6 guarded right after unlock");
            wr(8'h54, 32'h5, 1'b1, "R6 top of window");
            wr(8'h58, 32'h6, 1'b1, "R7 just above window");
            idle(8'h0, 32'h0);
            chk_open(1'b1, "R2 both keys");
            idle(B_ADR, 32'h0);
            idle(A_ADR, 32'h0);
            chk_open(1'b1, "R10 no strobe no effect");
            wr(B_ADR, 32'h0, 1'b0, "R8 slot B zero");
            wr(8'h10, 32'h7, 1'b0, "R4 guarded after relock");
            idle(8'h0, 32'h0);
            chk_open(1'b0, "R4 zero relocks");
            wr(B_ADR, B_KEY, 1'b0, "R8 slot B rekey");
            idle(8'h0, 32'h0);
            chk_open(1'b1, "R4 other slot kept key");
            wr(A_ADR, 32'hDEAD_BEEF, 1'b0, "R8 slot A bad word");
            wr(8'h80, 32'h8, 1'b1, "R7 unguarded while closed");
            idle(8'h0, 32'h0);
            chk_open(1'b0, "R4 bad word relocks");
            wr(A_ADR, A_KEY, 1'b0, "R8 slot A reverse order");
            idle(8'h0, 32'h0);
            chk_open(1'b1, "R2 reverse order opens");
            wr(A_ADR, 32'h0, 1'b0, "R8 lock A");
            wr(B_ADR, 32'h0, 1'b0, "R8 lock B");
            idle(8'h0, 32'h0);
            chk_open(1'b0, "R4 both zero");
            wr(A_ADR, B_KEY, 1'b0, "R8 swap A");
            wr(B_ADR, A_KEY, 1'b0, "R8 swap B");
            wr(8'h20, 32'h9, 1'b0, "R9 guarded dropped swapped");
            idle(8'h0, 32'h0);
            chk_open(1'b0, "R9 swapped keys closed");
            if (exp_q.size() != 0) begin
               checks++; failures++;
               $display("FAIL scoreboard: %0d items left expected=0", exp_q.size());
            end
         end
         begin
            repeat (5000) @(posedge clk);
            checks++; failures++;
            $display("FAIL watchdog: run hung actual=timeout expected=done");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule